// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A controller pulses a start strobe together with the first column, a coded burst length and a burst order. From the next clock on, the block presents one column per cycle with a valid flag, and it marks the final beat of a fixed-length burst. Full-page bursts step through the entire column space and wrap around. They keep running until a stop pulse or a new start ends them.

Only the low bits of the column move inside a fixed-length burst. Those bits wrap within the aligned block of burst-length columns, and the upper bits keep their start value. In sequential order the moving bits count upward from the start offset. In interleaved order they are the start offset XOR the beat number. The column width is the parameter `COL_W`, intended to be 9, 10 or 11 bits. A start strobe is accepted on any cycle, including in the middle of a burst, so column commands can be issued back to back.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and after it until the first start, valid_o, last_o and col_o are all 0. col_o reads 0 on every cycle in which valid_o is 0.
- R2: When start_i is sampled high at a clock edge, valid_o is 1 after that edge and col_o equals the start_col_i sampled at that edge.
- R3: blen_i codes 0, 1, 2 and 3 select fixed bursts of 1, 2, 4 and 8 beats. A fixed burst presents exactly that many valid beats on consecutive cycles, and valid_o is 0 in the cycle after the last beat unless a new start was sampled.
- R4: In sequential order (order_i = 0), beat k of a fixed burst of length L has low log2(L) bits equal to (start low bits + k) mod L. Its upper bits equal those of the start column.
- R5: In interleaved order (order_i = 1), beat k of a fixed burst has low log2(L) bits equal to the start low bits XOR k. Its upper bits equal those of the start column.
- R6: last_o is 1 on the final beat of a fixed burst and 0 on every other cycle.
- R7: Any blen_i code with bit 2 set (4 to 7) selects full page. Beat k is (start + k) mod 2^COL_W in either order, so it wraps from the top column to 0. The burst runs until stopped, and last_o stays 0.
- R8: When stop_i is sampled high with start_i low, valid_o is 0 after that edge. Beats already presented are unchanged. A stop while idle has no visible effect.
- R9: A start sampled during a burst abandons the old burst and restarts with the new column, length and order after that edge. When start_i and stop_i are high together, the start wins.
- R10: Changes on start_col_i, blen_i and order_i while start_i is low do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Column command strobe: begin a burst |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Length code: 0..3 for 1/2/4/8 beats, bit 2 set for full page |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst stop: end the current burst |
| valid_o | output | 1 | A beat column is presented |
| col_o | output | COL_W | Column of the current beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Beat 0 is due in the cycle after the edge that samples the start strobe, and each later beat is due exactly one cycle after the one before it. After the edge that samples a stop pulse, or the edge that follows a last beat, valid_o must be low. The driver raises strobes just after a rising edge and counts whole cycles before the next strobe, so each truncation lands on a known beat. It queues exactly the beats that must appear. The monitor compares every valid beat at the falling edge and flags any beat that arrives with nothing expected. Idle windows are also checked cycle by cycle just after the edge where valid_o must drop.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [0:0] {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;

  // Length code width and number of low bits a fixed burst can move.
  localparam int LEN_CODE_W     = 3;
  localparam int MAX_FIXED_LOG2 = 3;
endpackage

// File: rtl/colgen_rst_sync.sv
module colgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic                  full_page_o,
  output logic [COL_W-1:0]      mask_o
);
  always_comb begin
    full_page_o = code_i[LEN_CODE_W-1];
    mask_o      = '0;
    for (int i = 0; i < MAX_FIXED_LOG2; i++) begin
      if (!code_i[LEN_CODE_W-1] && (int'(code_i[1:0]) > i)) begin
        mask_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             full_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             at_end;

  assign at_end = active_q && !full_i && (beat_q == mask_i);

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (load_i) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (stop_i) begin
      active_d = 1'b0;
      beat_d   = '0;
    end else if (active_q) begin
      if (at_end) begin
        active_d = 1'b0;
        beat_d   = '0;
      end else begin
        beat_d = beat_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign last_o   = at_end;

  // A fixed burst never counts past its mask: R3
  assert_beat_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !full_i) |-> ((beat_q & ~mask_i) == '0));
endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  burst_order_e     order_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] low_bits;

  always_comb begin
    seq_sum = start_col_i + beat_i;
    if (order_i == ORD_ILV) begin
      low_bits = (start_col_i ^ beat_i) & mask_i;
    end else begin
      low_bits = seq_sum & mask_i;
    end
    if (full_i) begin
      col_o = seq_sum;
    end else begin
      col_o = (start_col_i & ~mask_i) | low_bits;
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] blen_i,
  input  logic                  order_i,
  input  logic                  stop_i,
  output logic                  valid_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             rst_int_n;
  logic             dec_full;
  logic [COL_W-1:0] dec_mask;

  logic             cfg_en;
  logic [COL_W-1:0] start_q, start_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             full_q, full_d;
  burst_order_e     order_q, order_d;

  logic             active;
  logic [COL_W-1:0] beat;
  logic             beat_last;
  logic [COL_W-1:0] calc_col;

  colgen_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  colgen_len_decode #(.COL_W(COL_W)) u_len_decode (
    .code_i      (blen_i),
    .full_page_o (dec_full),
    .mask_o      (dec_mask)
  );

  // Burst configuration is captured only on a start strobe.
  assign cfg_en = start_i;

  always_comb begin
    start_d = start_q;
    mask_d  = mask_q;
    full_d  = full_q;
    order_d = order_q;
    if (cfg_en) begin
      start_d = start_col_i;
      mask_d  = dec_mask;
      full_d  = dec_full;
      order_d = burst_order_e'(order_i);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_q <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= ORD_SEQ;
    end else begin
      start_q <= start_d;
      mask_q  <= mask_d;
      full_q  <= full_d;
      order_q <= order_d;
    end
  end

  colgen_beat_ctr #(.COL_W(COL_W)) u_beat_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (start_i),
    .stop_i   (stop_i),
    .full_i   (full_q),
    .mask_i   (mask_q),
    .active_o (active),
    .beat_o   (beat),
    .last_o   (beat_last)
  );

  colgen_addr_calc #(.COL_W(COL_W)) u_addr_calc (
    .start_col_i (start_q),
    .beat_i      (beat),
    .mask_i      (mask_q),
    .order_i     (order_q),
    .full_i      (full_q),
    .col_o       (calc_col)
  );

  assign valid_o = active;
  assign col_o   = active ? calc_col : '0;
  assign last_o  = beat_last;

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && last_o && !start_i) |=> !valid_o);

  assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && !full_q && !last_o && !start_i && !stop_i)
      |=> (valid_o && ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))));

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    last_o |-> valid_o);

  assert_full_page_step_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && full_q && !start_i && !stop_i)
      |=> (valid_o && !last_o && col_o == $past(col_o) + ONE));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_i && !start_i) |=> !valid_o);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !valid_o |-> (col_o == '0 && !last_o));
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int COL_W = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            req;
  } beat_t;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       blen_i;
  logic             order_i;
  logic             stop_i;
  logic             valid_o;
  logic [COL_W-1:0] col_o;
  logic             last_o;

  int checks;
  int failures;
  bit done;
  beat_t exp_q[$];

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .order_i     (order_i),
    .stop_i      (stop_i),
    .valid_o     (valid_o),
    .col_o       (col_o),
    .last_o      (last_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c,
                                               input logic [2:0] code,
                                               input logic ord, input int k);
    int unsigned bl, off, base, low;
    if (code[2]) return COL_W'((int'(c) + k) % (1 << COL_W));
    bl   = 1 << code[1:0];
    off  = int'(c) % bl;
    base = int'(c) - off;
    low  = ord ? (off ^ k) : ((off + k) % bl);
    return COL_W'(base + low);
  endfunction

  // Driver: queue the n beats that must appear, pulse start for one cycle.
  task automatic issue(input logic [COL_W-1:0] c, input logic [2:0] code,
                       input logic ord, input int n, input logic with_stop,
                       input string req);
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.col  = exp_col(c, code, ord, k);
      b.last = !code[2] && (k == (1 << code[1:0]) - 1);
      b.req  = req;
      exp_q.push_back(b);
    end
    start_col_i = c;
    blen_i      = code;
    order_i     = ord;
    start_i     = 1'b1;
    stop_i      = with_stop;
    @(posedge clk); #2;
    start_i     = 1'b0;
    stop_i      = 1'b0;
    // R10: scramble captured inputs while the burst runs
    start_col_i = ~c;
    blen_i      = code ^ 3'b011;
    order_i     = ~ord;
  endtask

  task automatic cycles(input int n);
    repeat (n) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic stop_now();
    stop_i = 1'b1;
    @(posedge clk); #2;
    stop_i = 1'b0;
  endtask

  task automatic idle_check(input int n, input string req);
    repeat (n) begin
      @(posedge clk); #2;
      checks++;
      if (valid_o || last_o || col_o != '0) begin
        failures++;
        $display("FAIL %s idle: valid=%0b last=%0b col=%0h expected valid=0 last=0 col=0",
                 req, valid_o, last_o, col_o);
      end
    end
  endtask

  // Monitor: compare each presented beat with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R3 unexpected beat: col=%0h last=%0b expected no beat", col_o, last_o);
        end else begin
          beat_t b;
          b = exp_q.pop_front();
          if (col_o !== b.col || last_o !== b.last) begin
            failures++;
            $display("FAIL %s beat: col=%0h last=%0b expected col=%0h last=%0b",
                     b.req, col_o, last_o, b.col, b.last);
          end
        end
      end else if (last_o) begin
        checks++;
        failures++;
        $display("FAIL R6 last without beat: last=1 expected 0");
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run still busy expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    done        = 1'b0;
    checks      = 0;
    failures    = 0;
    rst_n       = 1'b0;
    start_i     = 1'b0;
    stop_i      = 1'b0;
    start_col_i = '0;
    blen_i      = '0;
    order_i     = 1'b0;
    cycles(4);
    checks++;
    if (valid_o || last_o || col_o != '0) begin
      failures++;
      $display("FAIL R1 reset: valid=%0b last=%0b col=%0h expected 0 0 0", valid_o, last_o, col_o);
    end
    rst_n = 1'b1;
    idle_check(4, "R1");

    // R4: sequential length 4, then R5 interleaved, back to back
    issue(10'h005, 3'd2, 1'b0, 4, 1'b0, "R4"); cycles(3);
    issue(10'h005, 3'd2, 1'b1, 4, 1'b0, "R5"); cycles(3);
    idle_check(2, "R3");

    // R4: length 8 wrapping inside the aligned block at the column top
    issue(10'h3FE, 3'd3, 1'b0, 8, 1'b0, "R4"); cycles(7);
    // R5: interleaved length 8
    issue(10'h0A3, 3'd3, 1'b1, 8, 1'b0, "R5"); cycles(7);
    // R3/R6: single beat, then length 2 in both orders
    issue(10'h123, 3'd0, 1'b0, 1, 1'b0, "R6");
    issue(10'h011, 3'd1, 1'b0, 2, 1'b0, "R3"); cycles(1);
    issue(10'h011, 3'd1, 1'b1, 2, 1'b0, "R5"); cycles(1);
    idle_check(2, "R3");

    // R7: full page with interleaved order requested, wraps past the top
    issue(10'h3FC, 3'd4, 1'b1, 8, 1'b0, "R7"); cycles(7);
    stop_now();
    idle_check(2, "R8");
    issue(10'h040, 3'd7, 1'b0, 20, 1'b0, "R7"); cycles(19);
    stop_now();
    idle_check(2, "R8");

    // R8: stop a length-8 burst after 3 beats
    issue(10'h210, 3'd3, 1'b0, 3, 1'b0, "R8"); cycles(2);
    stop_now();
    idle_check(3, "R8");
    // R8: stop while idle
    stop_now();
    idle_check(3, "R8");

    // R9: restart after 2 beats with a new column, length and order
    issue(10'h155, 3'd3, 1'b0, 2, 1'b0, "R9"); cycles(1);
    issue(10'h2A6, 3'd2, 1'b1, 4, 1'b0, "R9"); cycles(3);
    idle_check(2, "R9");
    // R9: start and stop together, start wins
    issue(10'h07D, 3'd2, 1'b0, 4, 1'b1, "R9"); cycles(3);
    idle_check(2, "R10");

    cycles(2);
    done = 1'b1;
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R3 missing beats: left=%0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule